// File: doc/BRIEF.md
# Dual Threshold Alarm Monitor

This block watches a set of sensor data streams and raises one of two independent alarm flags when a programmed condition is met. Each channel picks a stream by a 4-bit code. It then compares one of two values against a signed threshold. In level mode the value is the current sample. In rate mode it is the change of that stream over a programmed number of samples. The sense bit of the threshold word sets the direction of the test.

The block evaluates a channel on every sample strobe. A hit sets a sticky status flag, which a status-read pulse clears. The two flags are ORed. The combined alarm can drive one of two output lines with a programmable active level, and the matching output-enable is raised for that line. All configuration arrives as static inputs, and the register access around the block lies outside it.

All stream inputs are 14-bit two's-complement words, right-aligned. Narrower unsigned sources are presented zero-extended, so they compare as positive values. Nine streams are supplied in a raw bus and nine in a filtered bus, and the stream in slot k occupies bits [14k+13:14k].

Top module: `dual_alarm_mon`

## Requirements
- R1: Source codes map to bus slots as follows: 0001→slot 0 (supply), 0010→1 (gyro), 0101→2, 0110→3, 0111→4 (accel X/Y/Z), 1000→5 (temperature), 1001→6, 1010→7 (inclinometer X/Y), 1011→8 (aux ADC). Code 0000 and every other code never set the channel status.
- R2: The threshold word's bit 15 selects the test: 1 means value > threshold, 0 means value < threshold. Bits 13:0 hold the signed threshold. Bit 14 is ignored.
- R3: In level mode (rate enable 0), a strobe whose current sample passes the test sets the status flag at the clock edge that samples the strobe.
- R4: In rate mode (rate enable 1), the tested value is the current sample minus the sample taken N strobes earlier, as a signed 15-bit quantity. A window setting of 0 or 1 both give N = 1.
- R5: Every strobe stores the channel's selected sample in a history of up to 255 entries. A rate test only fires once at least N samples have been stored since reset.
- R6: When the shared filter select is 1, comparisons use the filtered bus, and otherwise the raw bus. Codes 1001 and 1010 always use the filtered bus.
- R7: Status is sticky. A clear pulse without a hit zeroes it at the next edge. A hit in the same cycle as a clear leaves the flag set. Without a strobe or a clear, the flag holds.
- R8: With output enable 1, line_oe_o is 01 when line select is 0 and 10 when line select is 1. With output enable 0, line_oe_o is 00.
- R9: The enabled line is driven to the polarity bit while either status flag is set, and to its inverse while both are clear. Lines that are not enabled read 0.
- R10: After reset, both status flags are 0 and the rate history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 1 | Sample strobe, one cycle per new sample |
| clr_i | input | 1 | Status read pulse, clears both flags |
| raw_i | input | 126 | Nine unfiltered 14-bit streams |
| filt_i | input | 126 | Nine filtered 14-bit streams |
| use_filt_i | input | 1 | 1 selects filtered streams |
| thr_a_i | input | 16 | Channel A threshold and sense bit |
| src_a_i | input | 4 | Channel A source code |
| roc_a_i | input | 1 | Channel A rate mode enable |
| win_a_i | input | 8 | Channel A rate window in samples |
| thr_b_i | input | 16 | Channel B threshold and sense bit |
| src_b_i | input | 4 | Channel B source code |
| roc_b_i | input | 1 | Channel B rate mode enable |
| win_b_i | input | 8 | Channel B rate window in samples |
| out_en_i | input | 1 | Alarm line enable |
| out_pol_i | input | 1 | Active level of alarm line |
| out_sel_i | input | 1 | 0 selects line 0, 1 selects line 1 |
| stat_o | output | 2 | Status flags, bit 0 channel A, bit 1 channel B |
| line_o | output | 2 | Alarm line levels |
| line_oe_o | output | 2 | Alarm line output enables |

## Verification
A sample strobe that satisfies a channel's test and a status-read clear can arrive in the same cycle, and set must win. The bench drives both pulses together with a sample that passes the test, and also with one that fails it. It checks that the flag stays at 1 in the first case and drops to 0 in the second. A random phase issues strobes and clears independently, so they collide many times under both level and rate modes. Every cycle is compared against a queue-based model that applies set-over-clear priority.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef struct packed {
    logic       ok;
    logic       incl;
    logic [3:0] slot;
  } src_map_t;

  function automatic src_map_t map_src(input logic [3:0] code);
    src_map_t m;
    m = '0;
    case (code)
      4'b0001: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd0};
      4'b0010: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd1};
      4'b0101: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd2};
      4'b0110: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd3};
      4'b0111: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd4};
      4'b1000: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd5};
      4'b1001: m = '{ok: 1'b1, incl: 1'b1, slot: 4'd6};
      4'b1010: m = '{ok: 1'b1, incl: 1'b1, slot: 4'd7};
      4'b1011: m = '{ok: 1'b1, incl: 1'b0, slot: 4'd8};
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alm_src_sel.sv
module alm_src_sel
  import alm_pkg::*;
#(
  parameter int DW   = 14,
  parameter int NSRC = 9
) (
  input  logic [NSRC*DW-1:0] raw_i,
  input  logic [NSRC*DW-1:0] filt_i,
  input  logic               use_filt_i,
  input  logic [3:0]         code_i,
  output logic [DW-1:0]      val_o,
  output logic               ok_o
);
  src_map_t m;
  int unsigned base;

  always_comb begin
    m     = map_src(code_i);
    base  = int'(m.slot) * DW;
    ok_o  = m.ok && (int'(m.slot) < NSRC);
    val_o = '0;
    if (ok_o) begin
      // inclinometer streams exist only in filtered form
      if (use_filt_i || m.incl) val_o = filt_i[base +: DW];
      else                      val_o = raw_i[base +: DW];
    end
  end
endmodule

// File: rtl/alm_channel.sv
module alm_channel #(
  parameter int DW    = 14,
  parameter int WIN_W = 8,
  parameter int THR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             clr_i,
  input  logic [DW-1:0]    val_i,
  input  logic             src_ok_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             roc_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             stat_o
);
  localparam int HD = 1 << WIN_W;

  logic [DW-1:0]    hist_q [HD];
  logic [WIN_W-1:0] wp_q, fill_q, n_eff, rd_idx;
  logic signed [DW:0] cur_s, past_s, diff_s, lhs_s, thr_s;
  logic armed, hit, stat_q;

  always_comb begin
    n_eff  = (win_i == '0) ? WIN_W'(1) : win_i;
    rd_idx = wp_q - n_eff;
    cur_s  = $signed({val_i[DW-1], val_i});
    past_s = $signed({hist_q[rd_idx][DW-1], hist_q[rd_idx]});
    diff_s = cur_s - past_s;
    lhs_s  = roc_i ? diff_s : cur_s;
    thr_s  = $signed({thr_i[DW-1], thr_i[DW-1:0]});
    armed  = src_ok_i && (!roc_i || (fill_q >= n_eff));
    hit    = thr_i[THR_W-1] ? (lhs_s > thr_s) : (lhs_s < thr_s);
  end

  always_ff @(posedge clk_i) begin
    if (smp_i) hist_q[wp_q] <= val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (smp_i) begin
        wp_q <= wp_q + WIN_W'(1);
        if (fill_q != '1) fill_q <= fill_q + WIN_W'(1);
      end
      if (smp_i && armed && hit) stat_q <= 1'b1;
      else if (clr_i)            stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/alm_out_drv.sv
module alm_out_drv #(
  parameter int NCH   = 2,
  parameter int NLINE = 2
) (
  input  logic [NCH-1:0]   stat_i,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic             sel_i,
  output logic [NLINE-1:0] line_o,
  output logic [NLINE-1:0] oe_o
);
  logic lvl;
  assign lvl = pol_i ? (|stat_i) : ~(|stat_i);

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    assign oe_o[l]   = en_i && (int'(sel_i) == l);
    assign line_o[l] = oe_o[l] && lvl;
  end
endmodule

// File: rtl/dual_alarm_mon.sv
module dual_alarm_mon #(
  parameter int DW    = 14,
  parameter int NSRC  = 9,
  parameter int WIN_W = 8,
  parameter int THR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               smp_i,
  input  logic               clr_i,
  input  logic [NSRC*DW-1:0] raw_i,
  input  logic [NSRC*DW-1:0] filt_i,
  input  logic               use_filt_i,
  input  logic [THR_W-1:0]   thr_a_i,
  input  logic [3:0]         src_a_i,
  input  logic               roc_a_i,
  input  logic [WIN_W-1:0]   win_a_i,
  input  logic [THR_W-1:0]   thr_b_i,
  input  logic [3:0]         src_b_i,
  input  logic               roc_b_i,
  input  logic [WIN_W-1:0]   win_b_i,
  input  logic               out_en_i,
  input  logic               out_pol_i,
  input  logic               out_sel_i,
  output logic [1:0]         stat_o,
  output logic [1:0]         line_o,
  output logic [1:0]         line_oe_o
);
  localparam int NCH = 2;

  logic [THR_W-1:0] thr [NCH];
  logic [3:0]       src [NCH];
  logic             roc [NCH];
  logic [WIN_W-1:0] win [NCH];

  assign thr[0] = thr_a_i;  assign thr[1] = thr_b_i;
  assign src[0] = src_a_i;  assign src[1] = src_b_i;
  assign roc[0] = roc_a_i;  assign roc[1] = roc_b_i;
  assign win[0] = win_a_i;  assign win[1] = win_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] val;
    logic          ok;

    alm_src_sel #(.DW(DW), .NSRC(NSRC)) u_sel (
      .raw_i      (raw_i),
      .filt_i     (filt_i),
      .use_filt_i (use_filt_i),
      .code_i     (src[c]),
      .val_o      (val),
      .ok_o       (ok)
    );

    alm_channel #(.DW(DW), .WIN_W(WIN_W), .THR_W(THR_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp_i),
      .clr_i    (clr_i),
      .val_i    (val),
      .src_ok_i (ok),
      .thr_i    (thr[c]),
      .roc_i    (roc[c]),
      .win_i    (win[c]),
      .stat_o   (stat_o[c])
    );
  end

  alm_out_drv #(.NCH(NCH), .NLINE(2)) u_out (
    .stat_i (stat_o),
    .en_i   (out_en_i),
    .pol_i  (out_pol_i),
    .sel_i  (out_sel_i),
    .line_o (line_o),
    .oe_o   (line_oe_o)
  );
endmodule

// File: rtl/alm_chk.sv
module alm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_i,
  input logic       clr_i,
  input logic [3:0] src_a_i,
  input logic [3:0] src_b_i,
  input logic       out_en_i,
  input logic       out_pol_i,
  input logic [1:0] stat_o,
  input logic [1:0] line_o,
  input logic [1:0] line_oe_o
);
  p_off_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_i == 4'h0 && !stat_o[0]) |=> !stat_o[0]);
  p_off_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_b_i == 4'h0 && !stat_o[1]) |=> !stat_o[1]);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !smp_i) |=> stat_o == 2'b00);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !smp_i) |=> $stable(stat_o));
  p_oe_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_oe_o));
  p_oe_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> line_oe_o == 2'b00);
  p_idle_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && stat_o == 2'b00) |-> (line_o == (out_pol_i ? 2'b00 : line_oe_o)));
endmodule

bind dual_alarm_mon alm_chk u_chk (.*);

// File: tb/sim_dual_alarm_mon.sv
module sim_dual_alarm_mon;
  localparam int DW = 14, NSRC = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp = 0, clr = 0, use_filt = 0;
  logic [15:0] thr [2];
  logic [3:0]  src [2];
  logic        roc [2];
  logic [7:0]  win [2];
  logic out_en = 0, out_pol = 0, out_sel = 0;
  logic [13:0] rv [NSRC];
  logic [13:0] fv [NSRC];
  logic [NSRC*DW-1:0] raw_bus, filt_bus;
  logic [1:0] stat, line, line_oe;

  int errors = 0, checks = 0;
  int hq [2][$];
  bit ms [2];

  always #4 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      raw_bus[k*DW +: DW]  = rv[k];
      filt_bus[k*DW +: DW] = fv[k];
    end
  end

  dual_alarm_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .clr_i(clr),
    .raw_i(raw_bus), .filt_i(filt_bus), .use_filt_i(use_filt),
    .thr_a_i(thr[0]), .src_a_i(src[0]), .roc_a_i(roc[0]), .win_a_i(win[0]),
    .thr_b_i(thr[1]), .src_b_i(src[1]), .roc_b_i(roc[1]), .win_b_i(win[1]),
    .out_en_i(out_en), .out_pol_i(out_pol), .out_sel_i(out_sel),
    .stat_o(stat), .line_o(line), .line_oe_o(line_oe)
  );

  function automatic int sx(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  function automatic int slot_of(input logic [3:0] c);
    case (c)
      4'd1: return 0;  4'd2: return 1;  4'd5: return 2;  4'd6: return 3;
      4'd7: return 4;  4'd8: return 5;  4'd9: return 6;  4'd10: return 7;
      4'd11: return 8;
      default: return -1;
    endcase
  endfunction

  function automatic logic [1:0] exp_oe();
    if (!out_en) return 2'b00;
    return out_sel ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] exp_line();
    logic act, lvl;
    act = ms[0] | ms[1];
    lvl = out_pol ? act : !act;
    return exp_oe() & {2{lvl}};
  endfunction

  task automatic check_now(input string tag);
    logic [1:0] es, el, eo;
    es = {ms[1], ms[0]};
    el = exp_line();
    eo = exp_oe();
    checks++;
    if (stat !== es || line !== el || line_oe !== eo) begin
      errors++;
      $display("FAIL %s: stat=%b line=%b oe=%b expected stat=%b line=%b oe=%b",
               tag, stat, line, line_oe, es, el, eo);
    end
  endtask

  // one clock with the currently driven inputs; model updates, then compare
  task automatic step(input string tag);
    for (int ch = 0; ch < 2; ch++) begin
      int s, cur, n, v, t;
      bit hit, nxt;
      s = slot_of(src[ch]);
      cur = 0;
      if (s >= 0) cur = (use_filt || src[ch] == 4'd9 || src[ch] == 4'd10) ? sx(fv[s]) : sx(rv[s]);
      nxt = ms[ch];
      hit = 0;
      if (smp && s >= 0) begin
        n = (win[ch] == 0) ? 1 : int'(win[ch]);
        t = sx(thr[ch][13:0]);
        if (!roc[ch]) begin
          v = cur;
          hit = thr[ch][15] ? (v > t) : (v < t);
        end else if (hq[ch].size() >= n) begin
          v = cur - hq[ch][n-1];
          hit = thr[ch][15] ? (v > t) : (v < t);
        end
      end
      if (smp && hit) nxt = 1;
      else if (clr)   nxt = 0;
      ms[ch] = nxt;
      if (smp) begin
        hq[ch].push_front(cur);
        if (hq[ch].size() > 255) void'(hq[ch].pop_back());
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_now(tag);
    smp = 0;
    clr = 0;
  endtask

  task automatic strobe(input string tag);
    smp = 1;
    step(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NSRC; k++) begin rv[k] = '0; fv[k] = '0; end
    for (int c = 0; c < 2; c++) begin
      thr[c] = '0; src[c] = '0; roc[c] = 0; win[c] = '0; ms[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_now("R10 reset state");

    // R5: rate arming on channel B, window 3, after empty history
    src[1] = 4'b0101; roc[1] = 1; win[1] = 8'd3;
    thr[1] = {1'b1, 1'b0, 14'd5};
    for (int k = 0; k < 5; k++) begin
      rv[2] = 14'(k * 100);
      strobe("R5 rate arms after N stored samples");
    end
    clr = 1; step("R7 clear");

    // R3/R2 level mode on channel A, gyro
    out_en = 1; out_pol = 1; out_sel = 0;
    src[0] = 4'b0010; thr[0] = {1'b1, 1'b0, 14'd100};
    src[1] = 4'b0000; roc[1] = 0;
    rv[1] = 14'd90;   strobe("R3 below greater-than threshold");
    rv[1] = 14'd150;  strobe("R3 above greater-than threshold");
    smp = 0; step("R7 hold without strobe");
    clr = 1; step("R7 clear without hit");
    thr[0] = {1'b0, 1'b0, 14'h3FCE}; // less than -50
    rv[1] = 14'h3FD8; strobe("R2 -40 not below -50");
    rv[1] = 14'h3FC4; strobe("R2 -60 below -50");
    clr = 1; step("R7 clear");
    thr[0] = {1'b1, 1'b1, 14'd100};
    rv[1] = 14'd150; strobe("R2 bit 14 ignored");
    clr = 1; step("R7 clear");

    // R1 disabled and unused codes, plus mapping
    thr[0] = {1'b1, 1'b0, 14'd0};
    for (int k = 0; k < NSRC; k++) rv[k] = 14'd1000;
    src[0] = 4'b0000; strobe("R1 code 0000 never alarms");
    src[0] = 4'b0011; strobe("R1 unused code never alarms");
    src[0] = 4'b1011; strobe("R1 aux slot mapping");
    clr = 1; step("R7 clear");
    rv[8] = 14'd0; rv[5] = 14'd50;
    src[0] = 4'b1000; strobe("R1 temperature slot mapping");
    clr = 1; step("R7 clear");

    // R4 rate window 0 and 1
    src[0] = 4'b0110; roc[0] = 1; thr[0] = {1'b1, 1'b0, 14'd5};
    win[0] = 8'd0;
    rv[3] = 14'd10; strobe("R4 rate window 0 first");
    rv[3] = 14'd20; strobe("R4 rate window 0 diff 10");
    clr = 1; step("R7 clear");
    win[0] = 8'd1;
    rv[3] = 14'd22; strobe("R4 rate window 1 diff 2");
    rv[3] = 14'd40; strobe("R4 rate window 1 diff 18");
    clr = 1; step("R7 clear");
    roc[0] = 0;

    // R6 filtered selection and inclinometer override
    thr[0] = {1'b1, 1'b0, 14'd500};
    src[0] = 4'b1001; rv[6] = 14'd0; fv[6] = 14'd900; use_filt = 0;
    strobe("R6 inclinometer uses filtered");
    clr = 1; step("R7 clear");
    src[0] = 4'b0111; rv[4] = 14'd0; fv[4] = 14'd900;
    strobe("R6 raw chosen, no hit");
    use_filt = 1; strobe("R6 filtered chosen, hit");

    // R7 collision: set wins over clear
    clr = 1; smp = 1; step("R7 set beats clear");
    fv[4] = 14'd10; clr = 1; smp = 1; step("R7 clear with failing sample");

    // R8/R9 line select and polarity
    rv[1] = 14'd200; fv[1] = 14'd200; src[1] = 4'b0010; thr[1] = {1'b1, 1'b0, 14'd100};
    strobe("R9 active high on line 0");
    out_sel = 1; step("R8 line 1 selected");
    out_pol = 0; step("R9 active low");
    clr = 1; step("R9 idle level active low");
    out_en = 0; step("R8 disabled no drive");

    // random mix
    for (int it = 0; it < 3000; it++) begin
      for (int k = 0; k < NSRC; k++) begin
        rv[k] = ($urandom % 4 == 0) ? 14'($urandom) : 14'($urandom % 64 - 32);
        fv[k] = ($urandom % 4 == 0) ? 14'($urandom) : 14'($urandom % 64 - 32);
      end
      if ($urandom % 40 == 0) begin
        for (int c = 0; c < 2; c++) begin
          src[c] = 4'($urandom);
          roc[c] = 1'($urandom);
          win[c] = ($urandom % 2) ? 8'($urandom % 6) : 8'($urandom);
          thr[c] = {1'($urandom), 1'($urandom), 14'($urandom % 64 - 32)};
        end
        use_filt = 1'($urandom);
        out_en = 1'($urandom); out_pol = 1'($urandom); out_sel = 1'($urandom);
      end
      smp = ($urandom % 10) < 7;
      clr = ($urandom % 10) < 2;
      step("R3/R4/R7/R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule